// File: doc/BRIEF.md
# HDLC Receive Deframer with In-Band Escaping

This block sits behind a bit-level demodulator and line decoder and turns a stream of already decoded bits, one per `bit_valid` pulse, into a byte stream for a downstream FIFO. It watches the most recent eight bits for the frame delimiter (0x7E) and for the abort sequence of seven consecutive ones. It removes the zero that a transmitter inserts after five ones, and packs the remaining data bits into bytes, the first bit received becoming bit 0.

The output is a single in-band byte stream rather than framed packets. Every received delimiter is written out as a 0x7E byte. A data byte that happens to equal 0x7E, 0x7F or 0x1B is written as the escape byte 0x1B followed by the byte itself, so a consumer can tell delimiters from payload. Each write is a one-cycle `out_push` that the block raises only while `out_full` is low. Whenever a write it needs finds the FIFO full, the block loses frame synchronisation and stays silent until the next delimiter.

Writing an escape and its data byte takes two cycles. During the second cycle `bit_ready` is low and the block takes no bit, so the bit source must hold its bit until `bit_ready` returns.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A bit is taken when `bit_valid` and `bit_ready` are both high at a rising clock edge. If the last eight taken bits, the newest in the LSB, equal 0x7E and `out_full` is low, `out_push` is high in that cycle with `out_byte` = 0x7E, and the block enters the receiving state. Back-to-back delimiters each produce one 0x7E byte.
- R2: If a delimiter completes while `out_full` is high, nothing is pushed and the block leaves the receiving state, so later data bits are ignored until the next delimiter.
- R3: When the last seven taken bits are all ones (abort), the block leaves the receiving state. Later bits produce no output until a delimiter is seen again.
- R4: While receiving, a taken 0 bit whose five predecessors are 1 and whose sixth predecessor is 0 is dropped as stuffing and does not enter the byte.
- R5: Data bits are packed least significant bit first: after eight kept data bits, the first one is bit 0 of the byte and the last one is bit 7.
- R6: A completed byte equal to 0x7E, 0x7F or 0x1B is pushed as 0x1B in the completing cycle, then as the byte itself in the next cycle. `bit_ready` is low during that next cycle only, and no bit is taken then.
- R7: If a completed byte, or its escape, finds `out_full` high, the block leaves the receiving state. A byte whose escape could not be written is not written either. A byte whose second write finds the FIFO full is lost after its escape.
- R8: Taken bits outside the receiving state never cause a push unless they complete a delimiter.
- R9: After reset the block is not receiving, `bit_ready` is high and `out_push` is low, and bits received before the reset do not affect bits received after it.
- R10: `out_push` is never high while `out_full` is high, and cycles with `bit_valid` low change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_valid | input | 1 | A decoded bit is offered on `bit_in` |
| bit_in | input | 1 | Decoded line bit |
| bit_ready | output | 1 | Low in the cycle that writes the data byte after an escape; no bit is taken then |
| out_push | output | 1 | Write strobe to the output FIFO |
| out_byte | output | 8 | Byte written when `out_push` is high |
| out_full | input | 1 | Output FIFO cannot accept a write this cycle |

## Verification
The assertions assume that `out_full` changes only between clock edges and reflects the writes already accepted. They also assume that the bit source never offers a bit while `bit_ready` is low, or treats an offered bit as taken only when `bit_ready` was high. The stimulus meets both conditions. The bench drives inputs at the falling edge, waits for `bit_ready` before each bit, and derives `out_full` from a never-draining FIFO model whose fill count advances one cycle after each observed push. The payload bits come from a transmitter model in the bench that inserts stuffing zeros. Delimiters and aborts are sent raw, so accidental delimiters appear only where a test places them on purpose.

// File: rtl/hdlc_rx_pkg.sv
// Shared constants and types for the HDLC receive deframer.
// Assumes octet-wide output and the common delimiter, abort and escape codes.
package hdlc_rx_pkg;
    localparam int unsigned OCTET_W   = 8;
    localparam int unsigned STUFF_RUN = 5;   // ones before an inserted zero
    localparam int unsigned ABORT_RUN = 7;   // ones that abort a frame

    typedef logic [OCTET_W-1:0] octet_t;

    localparam octet_t DELIM_CODE = 8'h7E;
    localparam octet_t ABORT_CODE = 8'h7F;
    localparam octet_t ESC_CODE   = 8'h1B;
endpackage

// File: rtl/hdlc_rx_history.sv
// Bit history window with delimiter, abort and stuffing detection.
// The detectors look at the window including the bit now offered, so
// a hit is known in the same cycle the bit is taken.
// Assumes HIST_W > ABORT_RUN and HIST_W > STUFF_RUN.
module hdlc_rx_history #(
    parameter int unsigned HIST_W    = 8,
    parameter int unsigned STUFF_RUN = 5,
    parameter int unsigned ABORT_RUN = 7,
    parameter logic [HIST_W-1:0] DELIM_PAT = 8'h7E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    output logic delim_hit,
    output logic abort_hit,
    output logic stuff_hit
);
    localparam int unsigned STUFF_W = STUFF_RUN + 1;
    localparam logic [STUFF_W-1:0] STUFF_PAT = {{STUFF_RUN{1'b1}}, 1'b0};

    logic [HIST_W-2:0] past_q;   // the HIST_W-1 bits taken before now
    logic [HIST_W-1:0] window;

    assign window = {past_q, bit_in};

    // Shift a taken bit into the window at the LSB end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            past_q <= '0;
        else if (shift_en)
            past_q <= window[HIST_W-2:0];
    end

    // Pattern detectors on the window that includes the offered bit.
    always_comb begin
        delim_hit = (window == DELIM_PAT);
        abort_hit = &window[ABORT_RUN-1:0];
        stuff_hit = (window[STUFF_W-1:0] == STUFF_PAT);
    end
endmodule

// File: rtl/hdlc_rx_assembler.sv
// LSB-first byte assembler. Each kept bit enters at the top and the
// accumulator shifts right, so the first bit lands at bit 0 when the
// byte completes. Completion is flagged in the cycle of the last bit.
// Assumes clear and take are never both needed for one bit.
module hdlc_rx_assembler #(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic              bit_in,
    output logic              done,
    output logic [WORD_W-1:0] word
);
    localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] acc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] merged;

    // Place the offered bit at the top of the accumulator.
    always_comb begin
        merged = acc_q | {bit_in, {(WORD_W-1){1'b0}}};
        done   = take && (cnt_q == LAST);
        word   = merged;
    end

    // Accumulate kept bits; restart on clear or completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || done) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            acc_q <= merged >> 1;
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_rx_emitter.sv
// Output writer. Writes delimiters and completed bytes to the FIFO port,
// prefixing reserved bytes with an escape and holding the byte for a
// second cycle. Reports a failed write whenever a needed write finds the
// FIFO full. While the held byte is pending, busy is high and the
// parent must raise no new request.
module hdlc_rx_emitter #(
    parameter int unsigned WORD_W = 8,
    parameter logic [WORD_W-1:0] DELIM = 8'h7E,
    parameter logic [WORD_W-1:0] ABORT = 8'h7F,
    parameter logic [WORD_W-1:0] ESC   = 8'h1B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              delim_req,
    input  logic              data_req,
    input  logic [WORD_W-1:0] data_word,
    input  logic              fifo_full,
    output logic              push,
    output logic [WORD_W-1:0] push_word,
    output logic              busy,
    output logic              write_fail
);
    logic              held_q;
    logic [WORD_W-1:0] held_word_q;
    logic              reserved;
    logic              hold_set;

    // Classify a completed byte against the in-band control codes.
    always_comb begin
        reserved = (data_word == DELIM) || (data_word == ABORT) || (data_word == ESC);
    end

    // Choose what to write this cycle; the held byte has priority.
    always_comb begin
        push       = 1'b0;
        push_word  = '0;
        write_fail = 1'b0;
        hold_set   = 1'b0;
        if (held_q) begin
            push       = !fifo_full;
            push_word  = held_word_q;
            write_fail = fifo_full;
        end else if (delim_req) begin
            push       = !fifo_full;
            push_word  = DELIM;
            write_fail = fifo_full;
        end else if (data_req) begin
            push       = !fifo_full;
            push_word  = reserved ? ESC : data_word;
            write_fail = fifo_full;
            hold_set   = reserved && !fifo_full;
        end
    end

    // Hold a reserved byte for one cycle after its escape is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q      <= 1'b0;
            held_word_q <= '0;
        end else begin
            held_q <= hold_set;
            if (hold_set)
                held_word_q <= data_word;
        end
    end

    assign busy = held_q;
endmodule

// File: rtl/hdlc_rx_deframer.sv
// HDLC receive deframer producing an escaped in-band byte stream.
// Takes one decoded bit per bit_valid while bit_ready is high, tracks
// frame synchronisation, drops stuffing zeros, assembles bytes and writes
// them through a push/full FIFO port. Loses synchronisation whenever a
// needed write finds the FIFO full. Assumes out_full is stable around
// the clock edge and reflects writes already accepted.
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned DATA_W    = OCTET_W,
    parameter int unsigned STUFF_LEN = STUFF_RUN,
    parameter int unsigned ABORT_LEN = ABORT_RUN,
    parameter logic [DATA_W-1:0] DELIM = DELIM_CODE,
    parameter logic [DATA_W-1:0] ABRT  = ABORT_CODE,
    parameter logic [DATA_W-1:0] ESC   = ESC_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              bit_ready,
    output logic              out_push,
    output logic [DATA_W-1:0] out_byte,
    input  logic              out_full
);
    logic              busy;
    logic              bit_take;
    logic              delim_hit, abort_hit, stuff_hit;
    logic              delim_evt, abort_evt, data_take;
    logic              word_done;
    logic [DATA_W-1:0] word;
    logic              write_fail;
    logic              rx_on_q;

    assign bit_ready = !busy;
    assign bit_take  = bit_valid && !busy;

    hdlc_rx_history #(
        .HIST_W    (DATA_W),
        .STUFF_RUN (STUFF_LEN),
        .ABORT_RUN (ABORT_LEN),
        .DELIM_PAT (DELIM)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (bit_take),
        .bit_in    (bit_in),
        .delim_hit (delim_hit),
        .abort_hit (abort_hit),
        .stuff_hit (stuff_hit)
    );

    // Decide what a taken bit means: delimiter, abort, data or nothing.
    always_comb begin
        delim_evt = bit_take && delim_hit;
        abort_evt = bit_take && !delim_hit && abort_hit;
        data_take = bit_take && !delim_hit && !abort_hit && rx_on_q && !stuff_hit;
    end

    hdlc_rx_assembler #(
        .WORD_W (DATA_W)
    ) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (delim_evt),
        .take   (data_take),
        .bit_in (bit_in),
        .done   (word_done),
        .word   (word)
    );

    hdlc_rx_emitter #(
        .WORD_W (DATA_W),
        .DELIM  (DELIM),
        .ABORT  (ABRT),
        .ESC    (ESC)
    ) u_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .delim_req  (delim_evt),
        .data_req   (word_done),
        .data_word  (word),
        .fifo_full  (out_full),
        .push       (out_push),
        .push_word  (out_byte),
        .busy       (busy),
        .write_fail (write_fail)
    );

    // Frame synchronisation: set by a written delimiter, cleared by an
    // abort or by any needed write that found the FIFO full.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_on_q <= 1'b0;
        else if (delim_evt)
            rx_on_q <= !out_full;
        else if (abort_evt || write_fail)
            rx_on_q <= 1'b0;
    end
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
// Property checker for the HDLC receive deframer, attached by bind.
// Keeps its own record of the bits taken so that delimiter and abort
// events can be related to the output port and the receive state.
module hdlc_rx_deframer_chk
    import hdlc_rx_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         bit_valid,
    input logic         bit_in,
    input logic         bit_ready,
    input logic         out_push,
    input logic [7:0]   out_byte,
    input logic         out_full,
    input logic         rx_on_q
);
    logic [6:0] seen_q;
    logic       taken;

    assign taken = bit_valid && bit_ready;

    // Track the last seven bits taken by the block.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= '0;
        else if (taken)
            seen_q <= {seen_q[5:0], bit_in};
    end

    // R10: no write while the FIFO reports full.
    a_r10_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        out_push |-> !out_full);

    // R1: a completed delimiter with room is written at once and syncs.
    a_r1_delim_written: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && ({seen_q, bit_in} == DELIM_CODE) && !out_full)
            |-> (out_push && out_byte == DELIM_CODE));

    // R2: a delimiter that meets a full FIFO leaves the block unsynced.
    a_r2_delim_full_unsync: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && ({seen_q, bit_in} == DELIM_CODE) && out_full) |=> !rx_on_q);

    // R3: seven ones in a row drop synchronisation.
    a_r3_abort_unsync: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && (&{seen_q[5:0], bit_in})) |=> !rx_on_q);

    // R6: a stall cycle always follows a written escape.
    a_r6_stall_after_escape: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_ready |-> $past(out_push && out_byte == ESC_CODE));

    // R6: the stall lasts a single cycle.
    a_r6_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_ready |=> bit_ready);

    // R9: the cycle after reset accepts bits.
    a_r9_ready_after_reset: assert property (@(posedge clk)
        !rst_n |=> bit_ready);
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .bit_ready (bit_ready),
    .out_push  (out_push),
    .out_byte  (out_byte),
    .out_full  (out_full),
    .rx_on_q   (rx_on_q)
);

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    wire        bit_ready;
    wire        out_push;
    wire  [7:0] out_byte;
    wire        out_full;

    int push_cnt   = 0;
    int push_limit = 1000000;
    int vectors    = 0;
    int errors     = 0;
    int ones_run   = 0;
    int stalls     = 0;
    int gap_mode   = 0;
    int bit_idx    = 0;
    bit seen       = 1'b0;
    logic [7:0] cap_q[$];
    logic [7:0] exp_q[$];

    assign out_full = (push_cnt >= push_limit);

    always #5 clk = ~clk;

    hdlc_rx_deframer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .bit_ready (bit_ready),
        .out_push  (out_push),
        .out_byte  (out_byte),
        .out_full  (out_full)
    );

    // FIFO model and capture: sample late in the cycle, count at the next fall.
    initial begin
        forever begin
            @(negedge clk);
            if (seen) push_cnt++;
            seen = 1'b0;
            #4;
            if (rst_n && out_push) begin
                seen = 1'b1;
                cap_q.push_back(out_byte);
            end
            if (rst_n && !bit_ready) stalls++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        while (!bit_ready) @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in    = 1'b0;
        if (gap_mode != 0) idle(bit_idx % 3);
        bit_idx++;
    endtask

    task automatic send_raw(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        ones_run = 0;
    endtask

    task automatic send_delim();
        send_raw(8'h7E);
    endtask

    task automatic send_data(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i]);
            if (v[i]) begin
                ones_run++;
                if (ones_run == 5) begin
                    send_bit(1'b0);
                    ones_run = 0;
                end
            end else begin
                ones_run = 0;
            end
        end
    endtask

    function automatic void exp_data(input logic [7:0] v);
        if (v == 8'h7E || v == 8'h7F || v == 8'h1B) exp_q.push_back(8'h1B);
        exp_q.push_back(v);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        bit_valid = 1'b0;
        idle(3);
        rst_n = 1'b1;
        ones_run = 0;
        idle(2);
        cap_q.delete();
        exp_q.delete();
        push_cnt = 0;
        stalls = 0;
    endtask

    task automatic compare(input string req);
        idle(4);
        chk(cap_q.size() == exp_q.size(), {req, " length"}, cap_q.size(), exp_q.size());
        for (int i = 0; i < cap_q.size() && i < exp_q.size(); i++)
            chk(cap_q[i] == exp_q[i], req, cap_q[i], exp_q[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R9: state right after reset.
        do_reset();
        #4;
        chk(bit_ready == 1'b1, "R9 ready after reset", bit_ready, 1);
        chk(out_push == 1'b0, "R9 no push after reset", out_push, 0);

        // R8: unsynchronised bits yield nothing.
        for (int i = 0; i < 48; i++) send_bit(1'b0);
        for (int i = 0; i < 4; i++) send_raw(8'h55);
        send_data(8'h7E);
        send_data(8'hFF);
        compare("R8 idle bits");

        // R9: a reset mid-frame loses synchronisation.
        send_delim();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        do_reset();
        send_data(8'h12);
        send_data(8'h34);
        compare("R9 reset drops sync");

        // R5: LSB-first packing.
        do_reset();
        send_delim(); send_data(8'h01); send_data(8'h80); send_delim();
        exp_q = '{8'h7E, 8'h01, 8'h80, 8'h7E};
        compare("R5 lsb first");

        // R1: shared and back-to-back delimiters.
        do_reset();
        send_delim(); send_delim(); send_data(8'h12); send_delim();
        send_delim(); send_data(8'h34); send_delim();
        exp_q = '{8'h7E, 8'h7E, 8'h12, 8'h7E, 8'h7E, 8'h34, 8'h7E};
        compare("R1 delimiters");

        // R4 R6 R10: every byte value, without and with idle gaps.
        for (int g = 0; g < 2; g++) begin
            do_reset();
            gap_mode = g;
            bit_idx = 0;
            send_delim();
            exp_q.push_back(8'h7E);
            for (int v = 0; v < 256; v++) begin
                send_data(8'(v));
                exp_data(8'(v));
            end
            send_delim();
            exp_q.push_back(8'h7E);
            compare(g == 0 ? "R4 R6 byte sweep" : "R10 byte sweep with gaps");
            chk(stalls == 3, "R6 stall cycles", stalls, 3);
        end
        gap_mode = 0;

        // R3: abort inside a frame.
        do_reset();
        send_delim(); send_data(8'h11); send_raw(8'h7F);
        send_data(8'h22); send_data(8'h33);
        send_delim(); send_data(8'h44); send_delim();
        exp_q = '{8'h7E, 8'h11, 8'h7E, 8'h44, 8'h7E};
        compare("R3 abort");

        // R2 R7: FIFO fills after each possible number of writes.
        for (int lim = 0; lim < 6; lim++) begin
            logic [7:0] full_seq[6];
            full_seq = '{8'h7E, 8'h41, 8'h1B, 8'h7E, 8'h42, 8'h7E};
            do_reset();
            push_limit = lim;
            send_delim(); send_data(8'h41); send_data(8'h7E); send_data(8'h42); send_delim();
            idle(4);
            push_limit = 1000000;
            send_data(8'h55); send_data(8'h56);
            send_delim(); send_data(8'h66); send_delim();
            for (int k = 0; k < lim; k++) exp_q.push_back(full_seq[k]);
            exp_q.push_back(8'h7E); exp_q.push_back(8'h66); exp_q.push_back(8'h7E);
            compare(lim == 0 ? "R2 delimiter into full fifo" : "R7 overflow drops sync");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule